// File: doc/BRIEF.md
# Fractional-N Divide Controller with Seeded Modulus Accumulator

This block sits beside the feedback divider of a fractional-N synthesizer and runs at the phase-detector reference rate. On every reference cycle it issues an integer divide value. That value is the programmed integer part plus a carry from a first-order accumulator. The accumulator adds the fractional numerator each cycle and wraps at a programmable modulus, so that over time the average divide ratio equals INT + FRAC/MOD.

A channel commit happens on any clock edge where the load strobe is high. It captures the integer, numerator and modulus inputs. It also reloads the accumulator with a phase seed that has been reduced modulo the modulus. The carry pattern is therefore a fixed function of FRAC, MOD and the seed. As a result, the output phase offset can be stepped by one part in MOD of a full cycle.

Alongside the divide value, the block reports the signed quantization error for the same cycle. It also raises a flag when the committed numerator is not below the modulus.

Top module: `fracn_sdm_ctrl`

## Requirements
- R1: After reset, and until the first commit, `n_out` is 0, `qerr_out` is 0 and `frac_err` is 0.
- R2: At a clock edge with `load` high, `int_in`, `frac_in` and `mod_in` are captured. The `n_out` and `qerr_out` values presented after that same edge already use the new values.
- R3: At edges with `load` low, changes on `int_in`, `frac_in`, `mod_in` and `phase_in` have no effect on the outputs.
- R4: Each cycle, the accumulator adds FRAC and wraps modulo MOD. `n_out` is INT+1 on a cycle that wraps and INT otherwise. `n_out` is INT_W+1 bits wide, so INT=255 with a carry gives 256.
- R5: `qerr_out` is a two's-complement value of MOD_W+1 bits. It equals FRAC − MOD on a carry cycle and FRAC otherwise.
- R6: On a commit, the accumulator starts from PHASE mod MOD. The k-th output after the commit edge (k = 1, 2, …) carries exactly when floor((S + k·FRAC)/MOD) exceeds floor((S + (k−1)·FRAC)/MOD), where S is the reduced seed.
- R7: If the committed FRAC is greater than or equal to MOD, `frac_err` is 1 until the next commit, and FRAC is treated as MOD−1.
- R8: A committed MOD of 0 is treated as a modulus of 1.
- R9: With an effective FRAC of 0, `n_out` stays at INT and `qerr_out` stays at 0 for every cycle.
- R10: Over the first MOD cycles after a commit, the number of carry cycles equals the effective FRAC.
- R11: If `load` is held high across several edges, each such edge recommits and reseeds. The output after each of those edges equals the first post-commit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Channel commit strobe |
| int_in | input | INT_W (8) | Integer part of the divide ratio |
| frac_in | input | MOD_W (12) | Fractional numerator |
| mod_in | input | MOD_W (12) | Fractional modulus |
| phase_in | input | MOD_W (12) | Accumulator seed before reduction |
| n_out | output | INT_W+1 (9) | Divide value for the current reference cycle |
| qerr_out | output | MOD_W+1 (13) | Signed quantization error for the current cycle |
| frac_err | output | 1 | Numerator was out of range at the last commit |

## Verification
The bench uses the package defaults, INT_W = 8 and MOD_W = 12.

These widths make it possible to reach the example channel of INT 144, FRAC 40, MOD 65. They also allow a seed larger than the modulus and the largest divide value of 256, using INT 255 with MOD 4095. Finally, they cover the degenerate moduli of 0 and 1.

Because MOD can be as large as 4095, the bench can count carries across a complete wrap period at the extreme modulus. In the same runs it scrambles the channel inputs while `load` is low.

// File: rtl/fracn_sdm_pkg.sv
package fracn_sdm_pkg;
  localparam int MOD_W = 12;
  localparam int INT_W = 8;

  typedef logic [MOD_W-1:0]        mod_t;
  typedef logic [INT_W-1:0]        int_t;
  typedef logic [INT_W:0]          n_t;
  typedef logic signed [MOD_W:0]   err_t;

  typedef struct packed {
    mod_t acc;
    logic carry;
  } step_t;

  // Zero modulus is read as one so the reduction never divides by zero.
  function automatic mod_t mod_fix(mod_t m);
    return (m == '0) ? mod_t'(1) : m;
  endfunction

  function automatic mod_t seed_reduce(mod_t p, mod_t m);
    return p % m;
  endfunction

  // One accumulator step; base and f are both below m, so one subtract suffices.
  function automatic step_t acc_step(mod_t base, mod_t f, mod_t m);
    step_t r;
    logic [MOD_W:0] sum;
    sum = {1'b0, base} + {1'b0, f};
    if (sum >= {1'b0, m}) begin
      r.carry = 1'b1;
      r.acc   = mod_t'(sum - {1'b0, m});
    end else begin
      r.carry = 1'b0;
      r.acc   = mod_t'(sum);
    end
    return r;
  endfunction

  function automatic err_t q_error(mod_t f, mod_t m, logic c);
    return c ? (err_t'({1'b0, f}) - err_t'({1'b0, m})) : err_t'({1'b0, f});
  endfunction
endpackage

// File: rtl/fracn_chan_reg.sv
module fracn_chan_reg
  import fracn_sdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  int_t int_in,
  input  mod_t frac_in,
  input  mod_t mod_in,
  input  mod_t phase_in,
  output int_t int_eff,
  output mod_t frac_eff,
  output mod_t mod_eff,
  output mod_t seed,
  output int_t int_q,
  output mod_t frac_q,
  output mod_t mod_q,
  output logic frac_err
);
  mod_t mod_new;
  mod_t frac_new;
  logic clamp_hit;
  logic err_q;

  assign mod_new   = mod_fix(mod_in);
  assign clamp_hit = (frac_in >= mod_new);
  assign frac_new  = clamp_hit ? (mod_new - mod_t'(1)) : frac_in;
  assign seed      = seed_reduce(phase_in, mod_new);

  assign int_eff  = load ? int_in   : int_q;
  assign frac_eff = load ? frac_new : frac_q;
  assign mod_eff  = load ? mod_new  : mod_q;
  assign frac_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q  <= '0;
      frac_q <= '0;
      mod_q  <= mod_t'(1);
      err_q  <= 1'b0;
    end else if (load) begin
      int_q  <= int_in;
      frac_q <= frac_new;
      mod_q  <= mod_new;
      err_q  <= clamp_hit;
    end
  end

  // R7
  clamp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (frac_in >= mod_fix(mod_in))) |=> (err_q && (frac_q == mod_q - mod_t'(1))));

  // R3
  hold_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(int_q) && $stable(frac_q) && $stable(mod_q) && $stable(err_q)));

  // R8
  nonzero_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q != '0));
endmodule

// File: rtl/fracn_accum.sv
module fracn_accum
  import fracn_sdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  mod_t seed,
  input  mod_t frac_eff,
  input  mod_t mod_eff,
  input  mod_t mod_q,
  output logic carry
);
  mod_t  acc_q;
  mod_t  base;
  step_t st;

  assign base  = load ? seed : acc_q;
  assign st    = acc_step(base, frac_eff, mod_eff);
  assign carry = st.carry;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= st.acc;
  end

  // R4
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q < mod_q));

  // R6
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (frac_eff == '0)) |=> (acc_q == $past(seed)));
endmodule

// File: rtl/fracn_sdm_ctrl.sv
module fracn_sdm_ctrl
  import fracn_sdm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [INT_W-1:0]        int_in,
  input  logic [MOD_W-1:0]        frac_in,
  input  logic [MOD_W-1:0]        mod_in,
  input  logic [MOD_W-1:0]        phase_in,
  output logic [INT_W:0]          n_out,
  output logic signed [MOD_W:0]   qerr_out,
  output logic                    frac_err
);
  int_t int_eff, int_q;
  mod_t frac_eff, mod_eff, seed, frac_q, mod_q;
  logic carry;
  n_t   n_q;
  err_t e_q;

  fracn_chan_reg u_chan (
    .clk(clk), .rst_n(rst_n), .load(load),
    .int_in(int_in), .frac_in(frac_in), .mod_in(mod_in), .phase_in(phase_in),
    .int_eff(int_eff), .frac_eff(frac_eff), .mod_eff(mod_eff), .seed(seed),
    .int_q(int_q), .frac_q(frac_q), .mod_q(mod_q), .frac_err(frac_err)
  );

  fracn_accum u_acc (
    .clk(clk), .rst_n(rst_n), .load(load), .seed(seed),
    .frac_eff(frac_eff), .mod_eff(mod_eff), .mod_q(mod_q), .carry(carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q <= '0;
      e_q <= '0;
    end else begin
      n_q <= {1'b0, int_eff} + n_t'(carry);
      e_q <= q_error(frac_eff, mod_eff, carry);
    end
  end

  assign n_out    = n_q;
  assign qerr_out = e_q;

  // R4
  n_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_out >= {1'b0, int_q}) && (n_out <= {1'b0, int_q} + n_t'(1)));

  // R5
  err_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qerr_out > -err_t'({1'b0, mod_q})) && (qerr_out < err_t'({1'b0, mod_q})));

  // R9
  zero_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (frac_q == '0)) |=> ((n_out == {1'b0, $past(int_q)}) && (qerr_out == '0)));
endmodule

// File: tb/tb_fracn_sdm_ctrl.sv
module tb_fracn_sdm_ctrl;
  localparam int IW = 8;
  localparam int MW = 12;
  localparam int NV = 8;
  localparam int V_INT [NV] = '{144, 144, 10, 50, 20, 33, 255, 1};
  localparam int V_FRC [NV] = '{40, 40, 0, 3, 9, 100, 4094, 1};
  localparam int V_MOD [NV] = '{65, 65, 65, 7, 9, 0, 4095, 2};
  localparam int V_PH  [NV] = '{26, 0, 30, 20, 0, 5, 4000, 3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [IW-1:0] int_in = '0;
  logic [MW-1:0] frac_in = '0, mod_in = '0, phase_in = '0;
  logic [IW:0] n_out;
  logic signed [MW:0] qerr_out;
  logic frac_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fracn_sdm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .load(load), .int_in(int_in), .frac_in(frac_in),
    .mod_in(mod_in), .phase_in(phase_in), .n_out(n_out), .qerr_out(qerr_out),
    .frac_err(frac_err)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint carry_at(longint s, longint f, longint m, longint k);
    return (s + k * f) / m - (s + (k - 1) * f) / m;
  endfunction

  task automatic check_cycle(string req, longint iv, longint f, longint m, longint s,
                             longint k, bit e);
    longint c;
    c = carry_at(s, f, m, k);
    chk(n_out == (iv + c), req, n_out, iv + c);
    chk(longint'(qerr_out) == (f - c * m), {req, " R5"}, qerr_out, f - c * m);
    chk(frac_err == e, {req, " R7"}, frac_err, e);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint m, f, s, csum, ncyc;
    bit e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, no commit yet
    repeat (2) @(negedge clk);
    chk(n_out == 0, "R1 n_out", n_out, 0);
    chk(qerr_out == 0, "R1 qerr", qerr_out, 0);
    chk(frac_err == 0, "R1 flag", frac_err, 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      int_in = IW'(V_INT[v]); frac_in = MW'(V_FRC[v]);
      mod_in = MW'(V_MOD[v]); phase_in = MW'(V_PH[v]);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      m = (V_MOD[v] == 0) ? 1 : V_MOD[v];   // R8
      e = (V_FRC[v] >= m);
      f = e ? m - 1 : V_FRC[v];
      s = V_PH[v] % m;                      // R6
      csum = 0;
      ncyc = m + 4;
      for (longint k = 1; k <= ncyc; k++) begin
        if (k > 1) @(negedge clk);
        // R2 at k=1, R4/R6 across the run, R9 when f is zero
        check_cycle((k == 1) ? "R2" : ((f == 0) ? "R9" : "R4 R6"), V_INT[v], f, m, s, k, e);
        if (k <= m) csum += longint'(n_out) - V_INT[v];
        if (k == ncyc / 2) begin
          // R3: scramble channel inputs with load low
          int_in = ~int_in; frac_in = ~frac_in; mod_in = 12'd3; phase_in = ~phase_in;
        end
      end
      chk(csum == f, "R10 carry count", csum, f);
    end

    // R11: load held over three edges reseeds each time
    @(negedge clk);
    int_in = 8'd144; frac_in = 12'd40; mod_in = 12'd65; phase_in = 12'd50;
    load = 1'b1;
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      check_cycle("R11", 144, 40, 65, 50, 1, 1'b0);
    end
    load = 1'b0;
    @(negedge clk);
    check_cycle("R11 after", 144, 40, 65, 50, 2, 1'b0);

    // R8/R7: modulus 1 with nonzero numerator clamps to zero
    @(negedge clk);
    int_in = 8'd9; frac_in = 12'd1; mod_in = 12'd1; phase_in = 12'd7;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check_cycle("R8 R7 mod1", 9, 0, 1, 0, 1, 1'b1);

    // R7: a later valid commit clears the flag
    @(negedge clk);
    frac_in = 12'd0; mod_in = 12'd5; phase_in = 12'd4;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check_cycle("R7 clear", 9, 0, 5, 4, 1, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule